// File: doc/BRIEF.md
# Two-Wire Serial Slave with Control Register File

This block lets a host on a two-wire serial bus (clock line plus open-drain data line) read and write a small bank of seventeen 8-bit control registers at addresses 0x00 to 0x10. Both bus lines are brought into the system clock domain before any decision is made. The slave answers to a 7-bit device address: the fixed upper nibble `1000` followed by three strap pins. The slave never drives the data line high. It only asserts an output enable that pulls the line low.

A write transfer carries the device address with the direction bit low. The next byte is the register pointer. Each byte after that is stored at the pointer, and the pointer then advances. A read transfer with the direction bit high returns bytes from the pointer set earlier. The pointer advances after each byte sent. At 0x10 the pointer stops rather than wrapping. A pointer value above 0x10 is refused. The whole register image is exported as a parallel bus for the rest of the chip.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset, register i holds `RST_BASE + i` (default base 0xA0), `sda_oe_o` is low and the slave is idle.
- R2: A byte after a start whose upper seven bits equal `{1000, dev_strap_i}` is acknowledged by holding `sda_oe_o` high for the 9th clock. Any other address gets no acknowledge, and the transfer that follows changes no register.
- R3: Bytes are shifted MSB first in both directions, and `sda_oe_o` only changes while the synchronized clock line is low.
- R4: A start is data falling while the clock is high, and a stop is data rising while the clock is high. A repeated start returns to address reception without a stop. After a stop the slave releases the data line and ignores clock pulses until the next start.
- R5: In a write (direction bit 0), the first byte after the address loads the pointer. Each later byte is written to the pointer and acknowledged, and the pointer then moves up by one.
- R6: The pointer saturates at 0x10, so extra written bytes overwrite register 0x10 and extra read bytes repeat it.
- R7: A pointer byte greater than 0x10 is not acknowledged, and the data bytes that follow it write nothing.
- R8: A read (direction bit 1) starts at the pointer left by an earlier write phase and advances by one after each byte sent.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and ends the transfer.
- R10: `regs_o[8*i +: 8]` shows register i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| dev_strap_i | input | 3 | Low three bits of the device address |
| regs_o | output | 8*(MAX_ADDR+1) | Register image, register i in bits 8*i+7 : 8*i |

## Verification
The bound checker watches several properties on every cycle. The data-line enable moves only while the clock line is low. A stop always leaves the line released. The master-acknowledge slot never sees the line driven. The pointer and every write address stay at or below 0x10, and the register image changes only on a write strobe. The directed scenarios are needed for the rest: the actual byte values returned by reads, saturation at 0x10 across long bursts, refusal of a wrong device address or an oversized pointer, repeated start, and clock pulses after a stop being ignored.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,  // waiting for a start
    PH_DEV,   // receiving device address byte
    PH_PTR,   // receiving register pointer
    PH_WR,    // receiving data bytes
    PH_RD,    // shifting a byte out
    PH_SACK,  // slave acknowledge slot
    PH_MACK   // master acknowledge slot
  } twi_phase_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
  parameter int         NREG     = 17,
  parameter int         AW       = 5,
  parameter logic [7:0] RST_BASE = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] image
);
  logic [NREG*8-1:0] img_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) img_q[i*8 +: 8] <= RST_BASE + 8'(i);
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (waddr == AW'(i)) img_q[i*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == AW'(i)) rdata = img_q[i*8 +: 8];
  end

  assign image = img_q;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int         MAX_ADDR   = 16,
  parameter int         AW         = 5,
  parameter logic [3:0] DEV_PREFIX = 4'b1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [2:0]    strap,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output twi_phase_e    phase
);
  localparam logic [7:0]    LAST_B = 8'(MAX_ADDR);
  localparam logic [AW-1:0] LAST_P = AW'(MAX_ADDR);

  twi_phase_e after_ack;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       ack_q, mack_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_P) ? p : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      after_ack <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '1;
      ack_q     <= 1'b0;
      mack_q    <= 1'b0;
      ptr       <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      we <= 1'b0;
      if (start_p) begin
        phase <= PH_DEV;
        cnt   <= '0;
        ack_q <= 1'b0;
      end else if (stop_p) begin
        phase <= PH_IDLE;
        ack_q <= 1'b0;
      end else begin
        case (phase)
          PH_DEV, PH_PTR, PH_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt   <= '0;
              phase <= PH_SACK;
              case (phase)
                PH_DEV: begin
                  if (sh[7:1] == {DEV_PREFIX, strap}) begin
                    ack_q     <= 1'b1;
                    after_ack <= sh[0] ? PH_RD : PH_PTR;
                  end else phase <= PH_IDLE;
                end
                PH_PTR: begin
                  if (sh <= LAST_B) begin
                    ack_q     <= 1'b1;
                    ptr       <= sh[AW-1:0];
                    after_ack <= PH_WR;
                  end else phase <= PH_IDLE;
                end
                default: begin
                  ack_q     <= 1'b1;
                  we        <= 1'b1;
                  waddr     <= ptr;
                  wdata     <= sh;
                  ptr       <= bump(ptr);
                  after_ack <= PH_WR;
                end
              endcase
            end
          end
          PH_SACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              phase <= after_ack;
              cnt   <= '0;
              if (after_ack == PH_RD) tx <= rd_data;
            end
          end
          PH_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                phase <= PH_MACK;
                ptr   <= bump(ptr);
              end else tx <= {tx[6:0], 1'b1};
            end
          end
          PH_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack_q) begin
                tx    <= rd_data;
                phase <= PH_RD;
              end else phase <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = ack_q | (phase == PH_RD && !tx[7]);
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter int         MAX_ADDR   = 16,
  parameter logic [3:0] DEV_PREFIX = 4'b1000,
  parameter logic [7:0] RST_BASE   = 8'hA0,
  parameter int         SYNC_FF    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [2:0]              dev_strap_i,
  output logic [(MAX_ADDR+1)*8-1:0] regs_o
);
  localparam int NREG = MAX_ADDR + 1;
  localparam int AW   = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic we;
  logic [AW-1:0] waddr, ptr;
  logic [7:0] wdata, rdata;
  twi_pkg::twi_phase_e phase;

  twi_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  twi_slave_fsm #(.MAX_ADDR(MAX_ADDR), .AW(AW), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .strap(dev_strap_i), .rd_data(rdata), .sda_oe(sda_oe_o),
    .we(we), .waddr(waddr), .wdata(wdata), .ptr(ptr), .phase(phase)
  );

  twi_reg_bank #(.NREG(NREG), .AW(AW), .RST_BASE(RST_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .image(regs_o)
  );
endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk #(
  parameter int MAX_ADDR = 16,
  parameter int AW       = 5,
  parameter int NREG     = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_s,
  input logic                stop_p,
  input logic                sda_oe,
  input logic                we,
  input logic [AW-1:0]       waddr,
  input logic [AW-1:0]       ptr,
  input logic [NREG*8-1:0]   image,
  input twi_pkg::twi_phase_e phase
);
  // R3
  oe_moves_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_s);
  // R4
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);
  // R9
  mack_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == twi_pkg::PH_MACK) |-> !sda_oe);
  // R6
  ptr_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= AW'(MAX_ADDR));
  // R7
  waddr_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr <= AW'(MAX_ADDR));
  // R10
  image_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(image));
endmodule

bind twi_regfile_slave twi_regfile_slave_chk #(
  .MAX_ADDR(MAX_ADDR), .AW(AW), .NREG(NREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p), .sda_oe(sda_oe_o),
  .we(we), .waddr(waddr), .ptr(ptr), .image(regs_o), .phase(phase)
);

// File: tb/tb_twi_regfile_slave.sv
module tb_twi_regfile_slave;
  localparam int NREG = 17;
  localparam int Q    = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'h8A;  // 1000_101 + write
  localparam logic [7:0] DEV_R = 8'h8B;  // 1000_101 + read

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs;
  logic [7:0] exp_r [NREG];
  int total = 0, bad = 0;
  logic oe_seen = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dev_strap_i(STRAP), .regs_o(regs)
  );

  always @(negedge clk) if (sda_oe) oe_seen = 1'b1;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl = 1'b1;   hold(Q);
    sda_m = 1'b0; hold(Q);
    scl = 1'b0;   hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl = 1'b1;   hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl = 1'b1;   hold(Q);
      scl = 1'b0;   hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl = 1'b1;   hold(Q);
    ack = ~sda_bus;
    scl = 1'b0;   hold(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      d[i] = sda_bus;
      scl = 1'b0;
    end
    hold(Q);
    sda_m = ~give_ack; hold(Q);
    scl = 1'b1; hold(Q);
    scl = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, regs[i*8 +: 8], exp_r[i]);
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);
    chk_regs("R1 R10 reset image");
  endtask

  task automatic t_single_write();
    logic a;
    bus_start();
    send_byte(DEV_W, a); chk("R2 address ack", {7'd0, a}, 8'h01);
    send_byte(8'h03, a); chk("R5 pointer ack", {7'd0, a}, 8'h01);
    send_byte(8'h5A, a); chk("R5 data ack", {7'd0, a}, 8'h01);
    bus_stop();
    exp_r[3] = 8'h5A;
    chk_regs("R5 R10 single write");
  endtask

  task automatic t_burst_saturate();
    logic a;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h0E, a);
    send_byte(8'h11, a); chk("R5 burst ack 0E", {7'd0, a}, 8'h01);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    send_byte(8'h44, a); chk("R6 ack past end", {7'd0, a}, 8'h01);
    bus_stop();
    exp_r[14] = 8'h11; exp_r[15] = 8'h22; exp_r[16] = 8'h44;
    chk_regs("R6 saturated burst");
  endtask

  task automatic t_wrong_device();
    logic a;
    oe_seen = 1'b0;
    bus_start();
    send_byte(8'h8C, a); chk("R2 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h02, a);
    send_byte(8'hEE, a);
    bus_stop();
    chk("R2 line never driven", {7'd0, oe_seen}, 8'h00);
    chk_regs("R2 no effect");
  endtask

  task automatic t_bad_pointer();
    logic a;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h11, a); chk("R7 pointer 11h nack", {7'd0, a}, 8'h00);
    send_byte(8'h77, a); chk("R7 following byte nack", {7'd0, a}, 8'h00);
    bus_stop();
    chk_regs("R7 nothing written");
  endtask

  task automatic t_read_burst();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h03, a); bus_stop();
    bus_start();
    send_byte(DEV_R, a); chk("R2 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1'b1, d); chk("R8 R3 read base", d, exp_r[3]);
    recv_byte(1'b1, d); chk("R8 read base+1", d, exp_r[4]);
    recv_byte(1'b0, d); chk("R8 read base+2", d, exp_r[5]);
    bus_stop();
  endtask

  task automatic t_read_saturate();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h0F, a); bus_stop();
    bus_start(); send_byte(DEV_R, a);
    recv_byte(1'b1, d); chk("R8 read 0F", d, exp_r[15]);
    recv_byte(1'b1, d); chk("R6 read 10", d, exp_r[16]);
    recv_byte(1'b0, d); chk("R6 read repeats 10", d, exp_r[16]);
    bus_stop();
  endtask

  task automatic t_repeated_start();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h07, a);
    bus_start();
    send_byte(DEV_R, a); chk("R4 ack after repeated start", {7'd0, a}, 8'h01);
    recv_byte(1'b0, d); chk("R4 read after repeated start", d, exp_r[7]);
    bus_stop();
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] d;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h02, a); bus_stop();
    bus_start(); send_byte(DEV_R, a);
    oe_seen = 1'b0;
    recv_byte(1'b0, d);
    oe_seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b1; hold(Q);
      scl = 1'b0; hold(Q);
    end
    chk("R9 released after nack", {7'd0, oe_seen}, 8'h00);
    bus_stop();
  endtask

  task automatic t_stray_clocks();
    logic a;
    bus_start(); send_byte(DEV_W, a); send_byte(8'h09, a); bus_stop();
    chk("R4 oe low after stop", {7'd0, sda_oe}, 8'h00);
    oe_seen = 1'b0;
    scl = 1'b0; hold(Q);
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b0; hold(Q);
      scl = 1'b1;   hold(Q);
      scl = 1'b0;   hold(Q);
    end
    bus_stop();
    chk("R4 no drive without start", {7'd0, oe_seen}, 8'h00);
    chk("R4 register 9 untouched", regs[9*8 +: 8], exp_r[9]);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'hA0 + 8'(i);
    hold(5);
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_single_write();
    t_burst_saturate();
    t_wrong_device();
    t_bad_pointer();
    t_read_burst();
    t_read_saturate();
    t_repeated_start();
    t_nack_release();
    t_stray_clocks();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule